// File: doc/BRIEF.md
# Addressable Tap Shift Register

This block is a one-bit serial delay line whose length is chosen at run time. A bit enters the chain on every clock edge at which the shift enable is high. The output is not fixed to the last stage. It is taken from the stage named by a tap-select input, so the same unit can add anywhere from one to sixteen cycles of latency. The main use is to give two datapaths with different pipeline depths the same total latency.

The last stage of the chain is also brought out on its own pin, whatever the tap select says. That pin can feed the serial input of a second unit, so chained units give delays longer than sixteen cycles. A build-time option puts a flip-flop after the tap multiplexer. The flip-flop adds one cycle and shortens the timing path seen by the logic that follows. All storage starts at zero when the device powers up. The shift chain has no reset port.

Top module: `tap_delay_line`

## Requirements
- R1: After power-up and before any enabled clock edge, every stage is zero, so both the serial output and the cascade output read 0.
- R2: With the shift enable held high, a tap select of value k (0 to 15) gives a serial output equal to the input bit applied k+1 enabled edges earlier. Value 0 taps the first stage and value 15 taps the sixteenth.
- R3: On an edge where the shift enable is low, no stage changes, whatever the value of the serial input.
- R4: In the combinational output mode, the tap multiplexer has no register in its path. A change of tap select shows on the serial output in the same cycle, with no clock edge needed.
- R5: The cascade output always equals the sixteenth stage, the input bit from 16 enabled edges earlier, for any tap select value.
- R6: When the cascade output of one unit drives the serial input of a second unit that has the same shift enable, the second unit's output with tap select k equals the input from 16+k+1 enabled edges earlier.
- R7: In the registered output mode, the output flip-flop loads the selected tap only on enabled edges. The total delay is therefore k+2 enabled edges, and the output holds while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every stage and the output flip-flop use its rising edge |
| shift_en_i | input | 1 | Shift enable; when it is high the chain advances by one stage |
| ser_i | input | 1 | Serial data input, which enters the first stage |
| tap_sel_i | input | 4 | Tap select; value k picks stage k+1 |
| ser_o | output | 1 | Selected tap, directly or through the optional output flip-flop |
| chain_o | output | 1 | Last stage of the chain, for feeding a following unit |

## Verification
The stage contents change at the enabled rising edge. The tapped output without the flip-flop follows the tap select with no clock at all. The cascade pin shows the sixteenth stage right after the edge. The registered output lags the selected tap by exactly one enabled edge. The bench drives every input half a period after the rising edge and compares all outputs a short time later, within the same cycle. This window shows both the result of the previous edge and the effect of a tap-select change made in that cycle. A behavioural history queue is updated at each rising edge and gives the expected value for each output at that same sampling point.

// File: rtl/tdl_pkg.sv
// Shared definitions for the addressable tap shift register.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tdl_pkg;

    // Output path variant chosen at build time.
    typedef enum logic [0:0] {
        OUT_COMB = 1'b0,
        OUT_FLOP = 1'b1
    } out_mode_e;

    // Default chain length; a tap select of STAGES-1 reaches the last stage.
    localparam int unsigned DEF_STAGES = 16;

    // Extra cycles added by the output path for a given mode.
    function automatic int unsigned out_latency(out_mode_e mode);
        return (mode == OUT_FLOP) ? 1 : 0;
    endfunction

endpackage

// File: rtl/tdl_chain.sv
// Serial shift chain of STAGES flops. Index 0 is the newest bit.
// Assumes power-up initial values of zero; there is no reset port by design.
module tdl_chain #(
    parameter int unsigned STAGES = 16
) (
    input  logic              clk_i,
    input  logic              shift_en_i,
    input  logic              ser_i,
    output logic [STAGES-1:0] stage_o
);

    logic [STAGES-1:0] stage_q = '0;

    // Advance the chain by one position on each enabled edge.
    always_ff @(posedge clk_i) begin
        if (shift_en_i) begin
            stage_q <= {stage_q[STAGES-2:0], ser_i};
        end
    end

    assign stage_o = stage_q;

endmodule

// File: rtl/tdl_tap_mux.sv
// Combinational tap selector: returns the stage picked by sel_i.
// Assumes STAGES >= 2; a select beyond the chain length returns the last stage.
module tdl_tap_mux #(
    parameter int unsigned STAGES = 16,
    localparam int unsigned SEL_W = $clog2(STAGES)
) (
    input  logic [STAGES-1:0] stage_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              tap_o
);

    // Pick one stage; out-of-range codes clamp to the deepest stage.
    always_comb begin
        tap_o = stage_i[STAGES-1];
        for (int i = 0; i < STAGES; i++) begin
            if (int'(sel_i) == i) begin
                tap_o = stage_i[i];
            end
        end
    end

endmodule

// File: rtl/tdl_out_stage.sv
// Output path: either a wire or one enable-gated flop, chosen by MODE.
// Assumes the flop powers up at zero and shares the chain's enable.
module tdl_out_stage #(
    parameter tdl_pkg::out_mode_e MODE = tdl_pkg::OUT_COMB
) (
    input  logic clk_i,
    input  logic shift_en_i,
    input  logic tap_i,
    output logic ser_o
);

    generate
        if (MODE == tdl_pkg::OUT_FLOP) begin : g_flop
            logic out_q = 1'b0;

            // Capture the selected tap on enabled edges only.
            always_ff @(posedge clk_i) begin
                if (shift_en_i) begin
                    out_q <= tap_i;
                end
            end

            assign ser_o = out_q;
        end else begin : g_comb
            assign ser_o = tap_i;
        end
    endgenerate

endmodule

// File: rtl/tap_delay_line.sv
// Addressable tap shift register: a run-time selectable 1..STAGES cycle delay.
// An optional output flop adds one cycle. chain_o exposes the last stage for cascading.
// Assumes all storage is zero at power-up; no reset is provided.
module tap_delay_line #(
    parameter int unsigned        STAGES   = tdl_pkg::DEF_STAGES,
    parameter tdl_pkg::out_mode_e OUT_MODE = tdl_pkg::OUT_COMB,
    localparam int unsigned       SEL_W    = $clog2(STAGES)
) (
    input  logic             clk_i,
    input  logic             shift_en_i,
    input  logic             ser_i,
    input  logic [SEL_W-1:0] tap_sel_i,
    output logic             ser_o,
    output logic             chain_o
);

    logic [STAGES-1:0] stage_q;
    logic              tap_comb;

    tdl_chain #(.STAGES(STAGES)) u_chain (
        .clk_i      (clk_i),
        .shift_en_i (shift_en_i),
        .ser_i      (ser_i),
        .stage_o    (stage_q)
    );

    tdl_tap_mux #(.STAGES(STAGES)) u_mux (
        .stage_i (stage_q),
        .sel_i   (tap_sel_i),
        .tap_o   (tap_comb)
    );

    tdl_out_stage #(.MODE(OUT_MODE)) u_out (
        .clk_i      (clk_i),
        .shift_en_i (shift_en_i),
        .tap_i      (tap_comb),
        .ser_o      (ser_o)
    );

    // Cascade output is the deepest stage, independent of the tap select.
    assign chain_o = stage_q[STAGES-1];

endmodule

// File: rtl/tap_delay_line_chk.sv
// Property checker for tap_delay_line, attached by bind below.
// Since there is no reset, a first-edge flag gates every clocked property.
module tap_delay_line_chk #(
    parameter int unsigned        STAGES   = 16,
    parameter tdl_pkg::out_mode_e OUT_MODE = tdl_pkg::OUT_COMB,
    localparam int unsigned       SEL_W    = $clog2(STAGES)
) (
    input logic              clk_i,
    input logic              shift_en_i,
    input logic              ser_i,
    input logic [SEL_W-1:0]  tap_sel_i,
    input logic              ser_o,
    input logic              chain_o,
    input logic [STAGES-1:0] stage_q,
    input logic              tap_comb
);

    logic started = 1'b0;

    // Mark that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk_i) begin
        started <= 1'b1;
    end

    // R1: power-up contents are zero.
    initial begin
        #0;
        a_init_zero_r1: assert (stage_q == '0);
    end

    // R2: an enabled edge loads the input into the first stage.
    p_head_load_r2: assert property (@(posedge clk_i) disable iff (!started)
        shift_en_i |=> stage_q[0] == $past(ser_i));

    // R2: an enabled edge moves every stage one step deeper.
    p_shift_step_r2: assert property (@(posedge clk_i) disable iff (!started)
        shift_en_i |=> stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0]));

    // R3: a disabled edge changes nothing in the chain.
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!started)
        !shift_en_i |=> $stable(stage_q));

    // R5: the cascade pin follows the stage just before it after an enabled edge.
    p_chain_r5: assert property (@(posedge clk_i) disable iff (!started)
        shift_en_i |=> chain_o == $past(stage_q[STAGES-2]));

    // R2/R5: selecting the deepest tap matches the cascade pin.
    p_last_tap_r5: assert property (@(posedge clk_i) disable iff (!started)
        (int'(tap_sel_i) == STAGES-1) |-> tap_comb == chain_o);

    generate
        if (OUT_MODE == tdl_pkg::OUT_FLOP) begin : g_flop_chk
            // R7: the output flop captures the selected tap on enabled edges.
            p_flop_load_r7: assert property (@(posedge clk_i) disable iff (!started)
                shift_en_i |=> ser_o == $past(tap_comb));
            // R7: the output flop holds on disabled edges.
            p_flop_hold_r7: assert property (@(posedge clk_i) disable iff (!started)
                !shift_en_i |=> $stable(ser_o));
        end
    endgenerate

endmodule

bind tap_delay_line tap_delay_line_chk #(.STAGES(STAGES), .OUT_MODE(OUT_MODE)) u_chk (
    .clk_i      (clk_i),
    .shift_en_i (shift_en_i),
    .ser_i      (ser_i),
    .tap_sel_i  (tap_sel_i),
    .ser_o      (ser_o),
    .chain_o    (chain_o),
    .stage_q    (stage_q),
    .tap_comb   (tap_comb)
);

// File: tb/tap_delay_line_bench.sv
`timescale 1ns/100ps
// Bench: unit A (combinational out), unit R (registered out, same inputs as A),
// unit B chained from A's cascade pin. A history queue is the reference.
module tap_delay_line_bench;

    logic       clk = 1'b0;
    logic       en = 1'b0;
    logic       din = 1'b0;
    logic [3:0] sel_a = 4'd0;
    logic [3:0] sel_b = 4'd0;
    logic       out_a, chain_a, out_r, chain_r, out_b, chain_b;

    int vectors = 0;
    int misses  = 0;
    bit hist[$];
    bit reg_model = 1'b0;

    always #2 clk = ~clk;

    tap_delay_line u_tap_delay_line (
        .clk_i(clk), .shift_en_i(en), .ser_i(din), .tap_sel_i(sel_a),
        .ser_o(out_a), .chain_o(chain_a));

    tap_delay_line #(.OUT_MODE(tdl_pkg::OUT_FLOP)) u_tap_delay_line_reg (
        .clk_i(clk), .shift_en_i(en), .ser_i(din), .tap_sel_i(sel_a),
        .ser_o(out_r), .chain_o(chain_r));

    tap_delay_line u_tap_delay_line_next (
        .clk_i(clk), .shift_en_i(en), .ser_i(chain_a), .tap_sel_i(sel_b),
        .ser_o(out_b), .chain_o(chain_b));

    function automatic bit stage_at(int k);
        return (k < hist.size()) ? hist[k] : 1'b0;
    endfunction

    task automatic chk(input logic act, input bit exp, input string tag);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the history model at the current sample point.
    task automatic compare_all(input string tap_tag);
        chk(out_a,   stage_at(int'(sel_a)),      tap_tag);
        chk(chain_a, stage_at(15),               "R5");
        chk(out_r,   reg_model,                  "R7");
        chk(out_b,   stage_at(16 + int'(sel_b)), "R6");
    endtask

    // One cycle: drive after the falling edge, compare, then advance the model at the rising edge.
    task automatic tick(input bit e, input bit d, input int sa, input int sb, input string tag);
        @(negedge clk);
        en = e; din = d; sel_a = 4'(sa); sel_b = 4'(sb);
        #0.5;
        compare_all(tag);
        @(posedge clk);
        if (e) begin
            reg_model = stage_at(sa);
            hist.push_front(d);
            if (hist.size() > 40) void'(hist.pop_back());
        end
    endtask

    initial begin
        #(200000 * 4);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R1: no enabled edges yet, all zero.
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, i * 5, 15 - i, "R1");
        // R2: sweep every tap with random data.
        for (int i = 0; i < 96; i++) tick(1'b1, 1'($urandom), i % 16, i % 16, "R2");
        // R4: tap select changes within a cycle, with no clock edge.
        for (int i = 0; i < 16; i++) begin
            tick(1'b1, 1'($urandom), int'($urandom % 16), 15 - i, "R4");
            sel_a = 4'(15 - i);
            #0.5;
            chk(out_a, stage_at(15 - i), "R4");
            sel_a = 4'(i);
            #0.5;
            chk(out_a, stage_at(i), "R4");
        end
        // R3: enable toggles and long holds while the input keeps moving.
        for (int i = 0; i < 40; i++) tick(1'((i % 5) == 0), 1'(i), i % 16, (i * 3) % 16, "R3");
        // R6: long enabled run to exercise the chained delay.
        for (int i = 0; i < 64; i++) tick(1'b1, 1'($urandom), int'($urandom % 16), i % 16, "R6");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule